// File: doc/BRIEF.md
# Passivity Control Law Datapath for a Single-Phase Inverter

Once per switching period this block produces the signed control word that sets the PWM modulator's duty for the next period. The word is a weighted sum of six terms. Three come from the sinusoidal voltage reference taken at the current period and at the two periods before it. The other three are the latest measured output voltage, inductor current and output current. The three weights on the reference are fixed at build time and folded into lookup tables, so no multiply is spent on them at run time. The three weights on the measurements are signed fixed-point inputs and share one multiplier.

A period-start strobe starts one computation. The strobe also steps the reference index and shifts the delay line of reference indices. A small controller walks one term per cycle through the states IDLE, REF_K, REF_K1, REF_K2, MUL_VOUT, MUL_IL, MUL_IOUT and FINISH. The transitions are:
- IDLE to REF_K on an accepted strobe.
- Each later state to the next one unconditionally.
- FINISH back to IDLE.

In FINISH the full-width sum is rounded to modulator units and clamped to the modulator range. The result is then compared with the previous word, and the block reports saturation and any period-to-period step larger than a limit set by an input.

The reference table length must be a power of two. The default is 1024 points per fundamental cycle, with a peak of 820 modulator units.

Top module: `pbc_law_core`

## Requirements
- R1: After reset, ctrl_word is 0, result_valid, sat_flag and slew_flag are 0, and the reference index and both delayed indices are 0.
- R2: A strobe sampled high at a rising edge while the block is idle starts a computation. result_valid is high for exactly one cycle, after the 8th rising edge counted from the strobe edge (the strobe edge is the first). ctrl_word, sat_flag and slew_flag change only at that edge and hold their values until the next result.
- R3: Each accepted strobe moves the delay line: the index at k-2 takes the index at k-1, the index at k-1 takes the index at k, and the index at k increases by one modulo 1024. Before the first strobe both delayed indices are 0, and the sample at index 0 is 0.
- R4: The reference sample at index n is computed as follows. Take p = n mod 512. The magnitude is floor(820·16·p·(512−p) / (5·512² − 4·p·(512−p))). The sample is positive for n < 512 and negative otherwise. The reference part of the sum is 2048·ref(k) − 1024·ref(k−1) + 512·ref(k−2), which is the weights 0.5, −0.25 and 0.125 in Q12.
- R5: The measured part of the sum is gv·vout + gi·iLF + go·iout. The gains are 16-bit two's-complement Q12 values (4096 = 1.0). The measurements are 13-bit two's-complement codes in −4095..4095. The block captures gains, measurements and slew limit at the accepted strobe edge.
- R6: The six terms are added at full width, with no intermediate rounding. The unclamped word is floor((S + 2048) / 4096), where S is the full sum.
- R7: The unclamped word is clamped to −820..+820. sat_flag is 1 exactly when clamping changed the value, so a word of exactly ±820 is not flagged.
- R8: slew_flag is 1 exactly when |new word − previous word| is greater than the 12-bit unsigned slew limit. The previous word is the last clamped result, or 0 after reset.
- R9: A strobe that arrives while a computation is in progress is ignored. It does not advance the reference index, does not restart the sequence, and does not recapture any input.
- R10: The reference index wraps from 1023 to 0. The sequence of samples repeats exactly every 1024 accepted strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_strobe | input | 1 | Start of a switching period |
| vout_code | input | 13 | Output voltage measurement, signed |
| il_code | input | 13 | Inductor current measurement, signed |
| iout_code | input | 13 | Output current measurement, signed |
| gain_vout | input | 16 | Q12 weight on output voltage, signed |
| gain_il | input | 16 | Q12 weight on inductor current, signed |
| gain_iout | input | 16 | Q12 weight on output current, signed |
| slew_limit | input | 12 | Largest allowed step between words, unsigned |
| ctrl_word | output | 11 | Clamped control word, signed |
| result_valid | output | 1 | One-cycle pulse when a new word is out |
| sat_flag | output | 1 | The last word was clamped |
| slew_flag | output | 1 | The last step exceeded the slew limit |

## Verification
With all measurements at zero, a run of more than a full fundamental cycle isolates the three reference tables. This checks the quarter-wave folding, the negative half and the index wrap. Each measurement channel is then swept on its own across its code range with one nonzero gain, which shows whether the right gain pairs with the right operand and whether the signs are right. All-extreme combinations test the full-width sum and saturation in both directions. Small odd inductor-current codes at a gain of 0.5 separate round-half-up from truncation. Targets placed exactly at ±820 and one step beyond, and at the slew limit and one beyond, locate both comparisons to the unit. A strobe injected mid-computation, together with a changed measurement, shows whether the sequencer restarted or the inputs were recaptured.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    localparam int IDX_N     = 1024;
    localparam int IDX_W     = $clog2(IDX_N);
    localparam int HALF_N    = IDX_N / 2;
    localparam int QUART_N   = IDX_N / 4;
    localparam int REF_AMP   = 820;
    localparam int REF_W     = 11;
    localparam int MEAS_W    = 13;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 12;
    localparam int TERM_W    = COEF_W + REF_W;
    localparam int PROD_W    = COEF_W + MEAS_W;
    localparam int ACC_W     = PROD_W + 4;
    localparam int OUT_W     = 11;
    localparam int OUT_MAX   = 820;
    localparam int LIM_W     = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REF_K,
        S_REF_K1,
        S_REF_K2,
        S_MUL_VOUT,
        S_MUL_IL,
        S_MUL_IOUT,
        S_FINISH
    } law_state_t;

    // Integer half-wave sine shape; symmetric about QUART_N.
    function automatic int ref_sample(input int p);
        longint num;
        longint den;
        num = longint'(REF_AMP) * 16 * longint'(p) * longint'(HALF_N - p);
        den = 5 * longint'(HALF_N) * longint'(HALF_N)
            - 4 * longint'(p) * longint'(HALF_N - p);
        return int'(num / den);
    endfunction
endpackage

// File: rtl/pbc_ref_rom.sv
module pbc_ref_rom
    import pbc_pkg::*;
#(
    parameter int COEF = 2048
) (
    input  logic [IDX_W-1:0]         idx,
    output logic signed [TERM_W-1:0] term
);
    // Quarter-wave table of coefficient-weighted samples.
    logic signed [TERM_W-1:0] rom [QUART_N+1];

    for (genvar g = 0; g <= QUART_N; g++) begin : g_entry
        assign rom[g] = TERM_W'(longint'(COEF) * longint'(ref_sample(g)));
    end

    logic [IDX_W-2:0] half_idx;
    logic [IDX_W-2:0] fold;
    logic             neg_half;

    assign half_idx = idx[IDX_W-2:0];
    assign neg_half = idx[IDX_W-1];

    always_comb begin
        if (int'(half_idx) <= QUART_N) begin
            fold = half_idx;
        end else begin
            fold = (IDX_W-1)'(HALF_N - int'(half_idx));
        end
    end

    assign term = neg_half ? -rom[fold] : rom[fold];
endmodule

// File: rtl/pbc_ref_seq.sv
module pbc_ref_seq
    import pbc_pkg::*;
#(
    parameter int COEF_K  = 2048,
    parameter int COEF_K1 = -1024,
    parameter int COEF_K2 = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     advance,
    output logic signed [TERM_W-1:0] term_k,
    output logic signed [TERM_W-1:0] term_k1,
    output logic signed [TERM_W-1:0] term_k2
);
    localparam int TAP_COEF [3] = '{COEF_K, COEF_K1, COEF_K2};

    logic [IDX_W-1:0]         idx_cur;
    logic [IDX_W-1:0]         idx_d1;
    logic [IDX_W-1:0]         idx_d2;
    logic [IDX_W-1:0]         tap_idx  [3];
    logic signed [TERM_W-1:0] tap_term [3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_cur <= '0;
            idx_d1  <= '0;
            idx_d2  <= '0;
        end else if (advance) begin
            idx_d2  <= idx_d1;
            idx_d1  <= idx_cur;
            idx_cur <= idx_cur + IDX_W'(1);
        end
    end

    assign tap_idx[0] = idx_cur;
    assign tap_idx[1] = idx_d1;
    assign tap_idx[2] = idx_d2;

    for (genvar j = 0; j < 3; j++) begin : g_tap
        pbc_ref_rom #(.COEF(TAP_COEF[j])) u_rom (
            .idx  (tap_idx[j]),
            .term (tap_term[j])
        );
    end

    assign term_k  = tap_term[0];
    assign term_k1 = tap_term[1];
    assign term_k2 = tap_term[2];

    a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> idx_cur == $past(idx_cur) + IDX_W'(1));
    a_r3_delay_shift: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (idx_d1 == $past(idx_cur)) && (idx_d2 == $past(idx_d1)));
    a_r9_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(idx_cur) && $stable(idx_d1) && $stable(idx_d2));
endmodule

// File: rtl/pbc_mac_fsm.sv
module pbc_mac_fsm
    import pbc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic signed [MEAS_W-1:0] vout_in,
    input  logic signed [MEAS_W-1:0] il_in,
    input  logic signed [MEAS_W-1:0] iout_in,
    input  logic signed [COEF_W-1:0] gv_in,
    input  logic signed [COEF_W-1:0] gi_in,
    input  logic signed [COEF_W-1:0] go_in,
    input  logic signed [TERM_W-1:0] ref_t0,
    input  logic signed [TERM_W-1:0] ref_t1,
    input  logic signed [TERM_W-1:0] ref_t2,
    output logic                     accept,
    output logic signed [ACC_W-1:0]  acc,
    output logic                     finish
);
    law_state_t state, state_nx;

    logic signed [MEAS_W-1:0] vout_q, il_q, iout_q;
    logic signed [COEF_W-1:0] gv_q, gi_q, go_q;
    logic signed [COEF_W-1:0] mul_a;
    logic signed [MEAS_W-1:0] mul_b;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  addend;
    logic                     acc_load;
    logic                     acc_add;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (strobe) state_nx = S_REF_K;
            S_REF_K:    state_nx = S_REF_K1;
            S_REF_K1:   state_nx = S_REF_K2;
            S_REF_K2:   state_nx = S_MUL_VOUT;
            S_MUL_VOUT: state_nx = S_MUL_IL;
            S_MUL_IL:   state_nx = S_MUL_IOUT;
            S_MUL_IOUT: state_nx = S_FINISH;
            S_FINISH:   state_nx = S_IDLE;
        endcase
    end

    // Shared multiplier operand select
    always_comb begin
        mul_a = '0;
        mul_b = '0;
        unique case (state)
            S_MUL_VOUT: begin mul_a = gv_q; mul_b = vout_q; end
            S_MUL_IL:   begin mul_a = gi_q; mul_b = il_q;   end
            S_MUL_IOUT: begin mul_a = go_q; mul_b = iout_q; end
            default:    begin mul_a = '0;   mul_b = '0;     end
        endcase
    end

    assign prod = PROD_W'(mul_a) * PROD_W'(mul_b);

    // Outputs of the controller
    always_comb begin
        accept   = 1'b0;
        acc_load = 1'b0;
        acc_add  = 1'b0;
        finish   = 1'b0;
        addend   = '0;
        unique case (state)
            S_IDLE:     accept = strobe;
            S_REF_K:    begin acc_load = 1'b1; addend = ACC_W'(ref_t0); end
            S_REF_K1:   begin acc_add  = 1'b1; addend = ACC_W'(ref_t1); end
            S_REF_K2:   begin acc_add  = 1'b1; addend = ACC_W'(ref_t2); end
            S_MUL_VOUT: begin acc_add  = 1'b1; addend = ACC_W'(prod);   end
            S_MUL_IL:   begin acc_add  = 1'b1; addend = ACC_W'(prod);   end
            S_MUL_IOUT: begin acc_add  = 1'b1; addend = ACC_W'(prod);   end
            S_FINISH:   finish = 1'b1;
        endcase
    end

    // Operand capture at the accepted strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vout_q <= '0;
            il_q   <= '0;
            iout_q <= '0;
            gv_q   <= '0;
            gi_q   <= '0;
            go_q   <= '0;
        end else if (accept) begin
            vout_q <= vout_in;
            il_q   <= il_in;
            iout_q <= iout_in;
            gv_q   <= gv_in;
            gi_q   <= gi_in;
            go_q   <= go_in;
        end
    end

    // Accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (acc_load) begin
            acc <= addend;
        end else if (acc_add) begin
            acc <= acc + addend;
        end
    end

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> state == S_REF_K);
    a_r2_finish_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FINISH |=> state == S_IDLE);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && strobe) |=> state != S_REF_K);
    a_r9_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(vout_q) && $stable(gv_q) && $stable(go_q));
endmodule

// File: rtl/pbc_out_stage.sv
module pbc_out_stage
    import pbc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [LIM_W-1:0]        slew_limit,
    input  logic                    finish,
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] ctrl_word,
    output logic                    result_valid,
    output logic                    sat_flag,
    output logic                    slew_flag
);
    localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1 <<< (COEF_FRAC - 1));
    localparam logic signed [ACC_W-1:0] HI_LIM   = ACC_W'(OUT_MAX);
    localparam logic signed [ACC_W-1:0] LO_LIM   = ACC_W'(-OUT_MAX);

    logic [LIM_W-1:0]         lim_q;
    logic signed [ACC_W-1:0]  rnd_sum;
    logic signed [ACC_W-1:0]  scaled;
    logic signed [OUT_W-1:0]  clamped;
    logic                     clip;
    logic signed [OUT_W+1:0]  step;
    logic [OUT_W+1:0]         step_mag;
    logic                     slew_hit;

    assign rnd_sum = acc + RND_HALF;
    assign scaled  = rnd_sum >>> COEF_FRAC;

    always_comb begin
        clip = 1'b1;
        if (scaled > HI_LIM) begin
            clamped = OUT_W'(OUT_MAX);
        end else if (scaled < LO_LIM) begin
            clamped = OUT_W'(-OUT_MAX);
        end else begin
            clamped = scaled[OUT_W-1:0];
            clip    = 1'b0;
        end
    end

    assign step     = (OUT_W+2)'(clamped) - (OUT_W+2)'(ctrl_word);
    assign step_mag = (step < 0) ? $unsigned(-step) : $unsigned(step);
    assign slew_hit = step_mag > {1'b0, lim_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else if (accept) begin
            lim_q <= slew_limit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word    <= '0;
            sat_flag     <= 1'b0;
            slew_flag    <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= finish;
            if (finish) begin
                ctrl_word <= clamped;
                sat_flag  <= clip;
                slew_flag <= slew_hit;
            end
        end
    end

    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word <= OUT_W'(OUT_MAX)) && (ctrl_word >= OUT_W'(-OUT_MAX)));
    a_r7_sat_at_rail: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |-> (ctrl_word == OUT_W'(OUT_MAX)) || (ctrl_word == OUT_W'(-OUT_MAX)));
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(ctrl_word) && $stable(sat_flag) && $stable(slew_flag));
endmodule

// File: rtl/pbc_law_core.sv
module pbc_law_core
    import pbc_pkg::*;
#(
    parameter int COEF_K  = 2048,
    parameter int COEF_K1 = -1024,
    parameter int COEF_K2 = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     period_strobe,
    input  logic signed [MEAS_W-1:0] vout_code,
    input  logic signed [MEAS_W-1:0] il_code,
    input  logic signed [MEAS_W-1:0] iout_code,
    input  logic signed [COEF_W-1:0] gain_vout,
    input  logic signed [COEF_W-1:0] gain_il,
    input  logic signed [COEF_W-1:0] gain_iout,
    input  logic [LIM_W-1:0]         slew_limit,
    output logic signed [OUT_W-1:0]  ctrl_word,
    output logic                     result_valid,
    output logic                     sat_flag,
    output logic                     slew_flag
);
    logic                     accept;
    logic                     finish;
    logic signed [ACC_W-1:0]  acc;
    logic signed [TERM_W-1:0] term_k, term_k1, term_k2;

    pbc_ref_seq #(
        .COEF_K  (COEF_K),
        .COEF_K1 (COEF_K1),
        .COEF_K2 (COEF_K2)
    ) u_ref_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept),
        .term_k  (term_k),
        .term_k1 (term_k1),
        .term_k2 (term_k2)
    );

    pbc_mac_fsm u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (period_strobe),
        .vout_in (vout_code),
        .il_in   (il_code),
        .iout_in (iout_code),
        .gv_in   (gain_vout),
        .gi_in   (gain_il),
        .go_in   (gain_iout),
        .ref_t0  (term_k),
        .ref_t1  (term_k1),
        .ref_t2  (term_k2),
        .accept  (accept),
        .acc     (acc),
        .finish  (finish)
    );

    pbc_out_stage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .slew_limit   (slew_limit),
        .finish       (finish),
        .acc          (acc),
        .ctrl_word    (ctrl_word),
        .result_valid (result_valid),
        .sat_flag     (sat_flag),
        .slew_flag    (slew_flag)
    );
endmodule

// File: tb/pbc_law_core_bench.sv
`timescale 1ns/1ps
module pbc_law_core_bench;
    localparam int     NPTS = 1024;
    localparam int     HPTS = 512;
    localparam longint W0 = 2048, W1 = -1024, W2 = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic signed [12:0] vout = '0, il = '0, io = '0;
    logic signed [15:0] gv = '0, gi = '0, go = '0;
    logic [11:0] slim = 12'd4095;
    logic signed [10:0] ctrl;
    logic valid, sat, slew;

    int checks = 0;
    int failures = 0;
    int kc = 0;
    longint prev_word = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pbc_law_core u_pbc_law_core (
        .clk(clk), .rst_n(rst_n), .period_strobe(strobe),
        .vout_code(vout), .il_code(il), .iout_code(io),
        .gain_vout(gv), .gain_il(gi), .gain_iout(go),
        .slew_limit(slim), .ctrl_word(ctrl), .result_valid(valid),
        .sat_flag(sat), .slew_flag(slew));

    function automatic longint bref(input int n);
        longint p, mag;
        p = n % HPTS;
        mag = (820 * 16 * p * (HPTS - p)) / (5 * HPTS * HPTS - 4 * p * (HPTS - p));
        return (n >= HPTS) ? -mag : mag;
    endfunction

    function automatic longint ref_part(input int k);
        longint s;
        s = W0 * bref(k % NPTS);
        if (k >= 1) s += W1 * bref((k - 1) % NPTS);
        if (k >= 2) s += W2 * bref((k - 2) % NPTS);
        return s;
    endfunction

    function automatic longint fdiv(input longint x);
        longint q;
        q = x / 4096;
        if ((x % 4096 != 0) && (x < 0)) q -= 1;
        return q;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic period(input int v, input int i_l, input int i_o,
                          input int a4, input int a5, input int a6,
                          input int lim, input string tag, input bit extra);
        longint s, r, e, d;
        bit es, ew;
        @(negedge clk);
        vout = 13'(v); il = 13'(i_l); io = 13'(i_o);
        gv = 16'(a4); gi = 16'(a5); go = 16'(a6);
        slim = 12'(lim);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        kc++;
        s = ref_part(kc) + longint'(a4) * v + longint'(a5) * i_l + longint'(a6) * i_o;
        r = fdiv(s + 2048);
        e = (r > 820) ? 820 : ((r < -820) ? -820 : r);
        es = (e != r);
        d = e - prev_word;
        if (d < 0) d = -d;
        ew = (d > lim);
        prev_word = e;
        for (int n = 2; n <= 7; n++) begin
            @(negedge clk);
            if (extra && n == 3) begin
                strobe = 1'b1;
                vout = 13'sd1234;
                slim = 12'd0;
            end
            if (n == 4) strobe = 1'b0;
        end
        check(valid == 1'b0, "R2", "valid early", valid, 0);
        @(negedge clk);
        check(valid == 1'b1, "R2", "valid at 8th edge", valid, 1);
        check(ctrl == e, tag, "ctrl_word", ctrl, e);
        check(sat == es, tag == "R8" ? "R8" : "R7", "sat_flag", sat, es);
        check(slew == ew, "R8", "slew_flag", slew, ew);
    endtask

    // Drive a word of exactly target (gain 1.0 on vout, no other measured term).
    task automatic period_target(input int target, input int lim, input string tag);
        longint base;
        base = fdiv(ref_part(kc + 1) + 2048);
        period(int'(target - base), 0, 0, 4096, 0, 0, lim, tag, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ctrl == 0, "R1", "ctrl after reset", ctrl, 0);
        check(valid == 0 && sat == 0 && slew == 0, "R1", "flags after reset",
              {valid, sat, slew}, 0);

        // R3 R4 R10: reference-only sweep beyond a full cycle
        for (int p = 0; p < NPTS + 6; p++) begin
            period(0, 0, 0, 0, 0, 0, 4095, (kc % NPTS == NPTS - 1) ? "R10" : "R4", 1'b0);
        end

        // R5: each measured channel on its own
        for (int v = -4095; v <= 4095; v += 117) period(v, 0, 0, 1500, 0, 0, 4095, "R5", 1'b0);
        for (int v = -4095; v <= 4095; v += 117) period(0, v, 0, 0, -2300, 0, 4095, "R5", 1'b0);
        for (int v = -4095; v <= 4095; v += 117) period(0, 0, v, 0, 0, 777, 4095, "R5", 1'b0);

        // R5 R6: extreme combinations, moderate and heavy gains
        for (int a = -1; a <= 1; a++)
            for (int b = -1; b <= 1; b++)
                for (int c = -1; c <= 1; c++) begin
                    period(a * 4095, b * 4095, c * 4095, 100, -150, 200, 4095, "R6", 1'b0);
                    period(a * 4095, b * 4095, c * 4095, -9000, 12000, 3000, 4095, "R7", 1'b0);
                end

        // R6: half-unit fractions
        for (int v = -7; v <= 7; v++) period(0, v, 0, 0, 2048, 0, 4095, "R6", 1'b0);

        // R7: rails and just beyond
        period(4095, 0, 0, 32767, 0, 0, 4095, "R7", 1'b0);
        period(-4095, 0, 0, 32767, 0, 0, 4095, "R7", 1'b0);
        period_target(820, 4095, "R7");
        period_target(821, 4095, "R7");
        period_target(-820, 4095, "R7");
        period_target(-821, 4095, "R7");

        // R8: step at and beyond the limit
        period_target(100, 4095, "R8");
        period_target(110, 10, "R8");
        period_target(121, 10, "R8");
        period_target(111, 10, "R8");
        period_target(100, 10, "R8");
        period_target(-500, 0, "R8");
        period_target(-500, 0, "R8");

        // R9: strobe mid-computation ignored, then a normal period
        period(300, 0, 0, 4096, 0, 0, 4095, "R9", 1'b1);
        period(-200, 0, 0, 4096, 0, 0, 4095, "R9", 1'b0);
        period(50, 40, 30, 4096, 4096, 4096, 4095, "R9", 1'b1);
        period(0, 0, 0, 0, 0, 0, 4095, "R9", 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule